// File: doc/BRIEF.md
# Flow-Through Synchronous Burst Memory

A clocked word memory with a four-beat burst address generator and a read path that does not add a pipeline stage. Address, chip selects, write controls, burst strobes and write data are all captured on the rising clock edge. In the cycle that follows, the read word comes straight from the array at the captured address. It is then gated by an output enable that acts without waiting for a clock edge. The word is built from lanes. Each lane carries eight data bits plus one parity bit, and each lane can be written on its own.

A burst is opened by either of two address strobes. One strobe is meant for a processor and is gated by the primary select; it always opens a read. The other strobe is meant for a cache controller and opens a read or a write, chosen by the write controls. Once a burst is open, cycles with both strobes high either step to the next beat address or stay on the current one, and each such cycle reads or writes as the write controls say. The beat order is linear or interleaved, taken from a mode pin when the burst opens. The shared data bus is modelled as separate write-data, read-data and read-valid ports. A sleep input is present but changes nothing.

Top module: `fts_burst_ram`

## Requirements
- R1: The device is selected only when `sel0_n` is 0, `sel1_n` is 0 and `sel2` is 1. A strobe start while not selected is a deselect: in the next cycle `rvalid` is 0 and `rdata` is 0. The burst is closed, so later cycles with both strobes high stay idle until a new start.
- R2: After reset, `rvalid` is 0 and `rdata` is 0.
- R3: `pstb_n` = 0 with `sel0_n` = 0 and the device selected opens a read at `addr_in`, even while `gwr_n` or the lane write controls ask for a write.
- R4: A write after a `pstb_n` start is made in the next cycle, with both strobes high and the write controls active. It lands at the current beat address when `adv_n` = 1.
- R5: `cstb_n` = 0 with the device selected (and no `pstb_n` start) opens a read, or a write at `addr_in` when a write is requested.
- R6: A write is requested when `gwr_n` = 0, or when `lane_gate_n` = 0 with at least one `lane_n` bit at 0. With `gwr_n` = 0, all lanes are written whatever `lane_gate_n` and `lane_n` are.
- R7: Lane k occupies word bits [9k+8:9k], with its parity bit as the lane MSB. Bit k of `lane_n` at 0 writes only lane k, and only while `lane_gate_n` = 0. With `lane_gate_n` = 1, the `lane_n` bits have no effect and the cycle is a read.
- R8: A cycle with both strobes high and `adv_n` = 1 keeps the current beat address.
- R9: With `seq_linear` = 1 sampled at the burst start, the two low address bits of beat n are (start + n) mod 4. The upper address bits stay fixed.
- R10: With `seq_linear` = 0 sampled at the burst start, the two low address bits of beat n are start XOR n.
- R11: `rvalid` is 1 only when the current cycle is a selected read and `oe_n` is 0. `rdata` is 0 whenever `rvalid` is 0. A change of `oe_n` takes effect at once, without a clock edge.
- R12: In a write cycle, `rvalid` is 0 even with `oe_n` at 0.
- R13: `snooze` has no effect on stored data or on reads.
- R14: In a read cycle, `rdata` shows the word at the beat address, including a write made to that address in the cycle just before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr_in | input | AW (8) | External word address |
| sel0_n | input | 1 | Primary select, active low; also gates `pstb_n` |
| sel1_n | input | 1 | Second select, active low |
| sel2 | input | 1 | Third select, active high |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write, active low |
| lane_gate_n | input | 1 | Lane write gate, active low |
| lane_n | input | LANES (4) | Per-lane write enables, active low |
| seq_linear | input | 1 | Beat order: 1 linear, 0 interleaved |
| snooze | input | 1 | Sleep request, no functional effect |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| wdata | input | LANES*LANE_W (36) | Write data |
| rdata | output | LANES*LANE_W (36) | Read data, 0 when not valid |
| rvalid | output | 1 | Read data is being driven |

## Verification
Two functions can meet in one cycle. A write committed by the previous cycle lands on the array at the same edge where the next cycle's address is captured, and the read of that cycle must show the new word. The bench provokes this by following a write with a read of the same address, and by mixing random writes and reads over a burst. Each read word is judged against a reference array that takes the write before it updates the beat. A second meeting point is a processor-strobe start that arrives together with active write controls. Here the read must win, and the write controls are honoured only in the next cycle.

// File: rtl/fts_pkg.sv
package fts_pkg;

   // kind of access captured at a clock edge
   typedef enum logic [1:0] {
      CYC_IDLE = 2'd0,
      CYC_RD   = 2'd1,
      CYC_WR   = 2'd2
   } cyc_e;

   // beats per burst is 2**BEAT_W
   localparam int BEAT_W = 2;

endpackage

// File: rtl/fts_cmd_decode.sv
module fts_cmd_decode
   import fts_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             sel0_n,
   input  logic             sel1_n,
   input  logic             sel2,
   input  logic             pstb_n,
   input  logic             cstb_n,
   input  logic             adv_n,
   input  logic             gwr_n,
   input  logic             lane_gate_n,
   input  logic [LANES-1:0] lane_n,
   input  logic             burst_open,
   output logic             cs_ok,
   output logic             wr_req,
   output logic [LANES-1:0] lane_mask,
   output cyc_e             nxt_kind,
   output logic             load,
   output logic             step,
   output logic             close
);

   logic p_start;
   logic any_lane;

   always_comb begin
      cs_ok    = !sel0_n && !sel1_n && sel2;
      any_lane = (lane_n != {LANES{1'b1}});
      wr_req   = !gwr_n || (!lane_gate_n && any_lane);
      if (!gwr_n)
         lane_mask = {LANES{1'b1}};
      else if (!lane_gate_n)
         lane_mask = ~lane_n;
      else
         lane_mask = '0;
   end

   // processor strobe counts only while the primary select is low
   assign p_start = !pstb_n && !sel0_n;

   always_comb begin
      nxt_kind = CYC_IDLE;
      load     = 1'b0;
      step     = 1'b0;
      close    = 1'b0;
      if (p_start) begin
         if (cs_ok) begin
            load     = 1'b1;
            nxt_kind = CYC_RD;
         end else begin
            close = 1'b1;
         end
      end else if (!cstb_n) begin
         if (cs_ok) begin
            load     = 1'b1;
            nxt_kind = wr_req ? CYC_WR : CYC_RD;
         end else begin
            close = 1'b1;
         end
      end else if (burst_open) begin
         step     = !adv_n;
         nxt_kind = wr_req ? CYC_WR : CYC_RD;
      end
   end

endmodule

// File: rtl/fts_burst_gen.sv
module fts_burst_gen
   import fts_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic [AW-1:0] start_addr,
   input  logic          seq_linear,
   output logic [AW-1:0] beat
);

   localparam int HI_W = AW - BEAT_W;

   logic [BEAT_W-1:0] lo_q;
   logic [BEAT_W-1:0] cnt_q;
   logic              lin_q;
   logic [BEAT_W-1:0] lo_beat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q  <= '0;
         cnt_q <= '0;
         lin_q <= 1'b0;
      end else if (load) begin
         lo_q  <= start_addr[BEAT_W-1:0];
         cnt_q <= '0;
         lin_q <= seq_linear;
      end else if (step) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign lo_beat = lin_q ? (lo_q + cnt_q) : (lo_q ^ cnt_q);

   generate
      if (HI_W > 0) begin : g_hi
         logic [HI_W-1:0] hi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               hi_q <= '0;
            else if (load)
               hi_q <= start_addr[AW-1:BEAT_W];
         end
         assign beat = {hi_q, lo_beat};

         AST_HI_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
            (!load) |=> (beat[AW-1:BEAT_W] == $past(beat[AW-1:BEAT_W])));  // R9
      end else begin : g_flat
         assign beat = lo_beat;
      end
   endgenerate

   AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step) |=> $stable(beat));  // R8

   AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && lin_q) |=>
         (beat[BEAT_W-1:0] == $past(beat[BEAT_W-1:0]) + 1'b1));  // R9

endmodule

// File: rtl/fts_lane_store.sv
module fts_lane_store #(
   parameter int DEPTH  = 256,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int AW    = $clog2(DEPTH),
   localparam int WORD_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [LANES-1:0]  mask,
   input  logic [AW-1:0]     addr,
   input  logic [WORD_W-1:0] wd,
   output logic [WORD_W-1:0] rd
);

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         logic [LANE_W-1:0] arr [DEPTH];
         always_ff @(posedge clk) begin
            if (we && mask[k])
               arr[addr] <= wd[k*LANE_W +: LANE_W];
         end
         assign rd[k*LANE_W +: LANE_W] = arr[addr];
      end
   endgenerate

endmodule

// File: rtl/fts_burst_ram.sv
module fts_burst_ram
   import fts_pkg::*;
#(
   parameter int DEPTH  = 256,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int AW     = $clog2(DEPTH),
   localparam int WORD_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     addr_in,
   input  logic              sel0_n,
   input  logic              sel1_n,
   input  logic              sel2,
   input  logic              pstb_n,
   input  logic              cstb_n,
   input  logic              adv_n,
   input  logic              gwr_n,
   input  logic              lane_gate_n,
   input  logic [LANES-1:0]  lane_n,
   input  logic              seq_linear,
   input  logic              snooze,
   input  logic              oe_n,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata,
   output logic              rvalid
);

   generate
      if (DEPTH < (1 << BEAT_W) || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("fts_burst_ram: DEPTH must be a power of two of at least 4");
      end
      if (LANES < 1 || LANE_W < 2) begin : g_bad_lane
         $error("fts_burst_ram: need at least one lane of two or more bits");
      end
   endgenerate

   logic              cs_ok;
   logic              wr_req;
   logic [LANES-1:0]  lane_mask;
   cyc_e              nxt_kind;
   logic              load;
   logic              step;
   logic              close;

   cyc_e              kind_q;
   logic              open_q;
   logic [LANES-1:0]  mask_q;
   logic [WORD_W-1:0] wd_q;
   logic [AW-1:0]     beat;
   logic [WORD_W-1:0] rd_word;
   logic              unused_snooze;

   assign unused_snooze = snooze;

   fts_cmd_decode #(.LANES(LANES)) u_dec (
      .sel0_n      (sel0_n),
      .sel1_n      (sel1_n),
      .sel2        (sel2),
      .pstb_n      (pstb_n),
      .cstb_n      (cstb_n),
      .adv_n       (adv_n),
      .gwr_n       (gwr_n),
      .lane_gate_n (lane_gate_n),
      .lane_n      (lane_n),
      .burst_open  (open_q),
      .cs_ok       (cs_ok),
      .wr_req      (wr_req),
      .lane_mask   (lane_mask),
      .nxt_kind    (nxt_kind),
      .load        (load),
      .step        (step),
      .close       (close)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= CYC_IDLE;
         open_q <= 1'b0;
         mask_q <= '0;
         wd_q   <= '0;
      end else begin
         kind_q <= nxt_kind;
         mask_q <= lane_mask;
         wd_q   <= wdata;
         if (load)
            open_q <= 1'b1;
         else if (close)
            open_q <= 1'b0;
      end
   end

   fts_burst_gen #(.AW(AW)) u_burst (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .step       (step),
      .start_addr (addr_in),
      .seq_linear (seq_linear),
      .beat       (beat)
   );

   fts_lane_store #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_store (
      .clk  (clk),
      .we   (kind_q == CYC_WR),
      .mask (mask_q),
      .addr (beat),
      .wd   (wd_q),
      .rd   (rd_word)
   );

   assign rvalid = (kind_q == CYC_RD) && !oe_n;
   assign rdata  = rvalid ? rd_word : '0;

   AST_DESEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!cstb_n && pstb_n && !cs_ok) |=> !rvalid);  // R1

   AST_PSTB_READS: assert property (@(posedge clk) disable iff (!rst_n)
      (!pstb_n && cs_ok) |=> (kind_q == CYC_RD));  // R3

   AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (pstb_n && !cstb_n && cs_ok && !gwr_n) |=> !rvalid);  // R12

   AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (pstb_n && !cstb_n && cs_ok && !gwr_n) |=> (mask_q == {LANES{1'b1}}));  // R6

endmodule

// File: tb/fts_burst_ram_test.sv
`timescale 1ns/1ps
module fts_burst_ram_test;

   localparam int DEPTH = 256;
   localparam int AW    = 8;
   localparam int W     = 36;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic          sel0_n = 1'b0, sel1_n = 1'b0, sel2 = 1'b1;
   logic          pstb_n = 1'b1, cstb_n = 1'b1, adv_n = 1'b1;
   logic          gwr_n = 1'b1, lane_gate_n = 1'b1;
   logic [3:0]    lane_n = 4'hF;
   logic          seq_linear = 1'b1, snooze = 1'b0, oe_n = 1'b0;
   logic [W-1:0]  wdata = '0;
   logic [W-1:0]  rdata;
   logic          rvalid;

   int n_chk = 0;
   int n_bad = 0;

   // reference state
   logic [W-1:0]  ref_mem [DEPTH];
   int            m_kind;   // 0 idle, 1 read, 2 write
   logic          m_open;
   logic [AW-1:0] m_base;
   logic [1:0]    m_cnt;
   logic          m_lin;
   logic [AW-1:0] m_addr;
   logic [3:0]    m_mask;
   logic [W-1:0]  m_wd;

   always #2.5 clk = ~clk;

   fts_burst_ram uut (
      .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
      .sel0_n(sel0_n), .sel1_n(sel1_n), .sel2(sel2),
      .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n),
      .gwr_n(gwr_n), .lane_gate_n(lane_gate_n), .lane_n(lane_n),
      .seq_linear(seq_linear), .snooze(snooze), .oe_n(oe_n),
      .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
   );

   function automatic logic [W-1:0] pat(input logic [AW-1:0] a);
      return {1'b1, a + 8'd3, 1'b0, a, 1'b1, ~a, 1'b0, a ^ 8'h3C};
   endfunction

   function automatic logic [AW-1:0] beat_of(input logic [AW-1:0] b,
                                             input logic [1:0] n,
                                             input logic lin);
      return {b[AW-1:2], lin ? (b[1:0] + n) : (b[1:0] ^ n)};
   endfunction

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // apply one clock edge to the reference, following the requirements
   task automatic model_edge();
      logic cs, wr, ld;
      logic [3:0] msk;
      if (m_kind == 2)
         for (int k = 0; k < 4; k++)
            if (m_mask[k]) ref_mem[m_addr][9*k +: 9] = m_wd[9*k +: 9];
      cs  = !sel0_n && !sel1_n && sel2;
      wr  = !gwr_n || (!lane_gate_n && lane_n != 4'hF);
      msk = !gwr_n ? 4'hF : (!lane_gate_n ? ~lane_n : 4'h0);
      ld  = 1'b0;
      if (!pstb_n && !sel0_n) begin
         if (cs) begin ld = 1'b1; m_kind = 1; end
         else begin m_kind = 0; m_open = 1'b0; end
      end else if (!cstb_n) begin
         if (cs) begin ld = 1'b1; m_kind = wr ? 2 : 1; end
         else begin m_kind = 0; m_open = 1'b0; end
      end else if (m_open) begin
         if (!adv_n) m_cnt = m_cnt + 2'd1;
         m_kind = wr ? 2 : 1;
      end else begin
         m_kind = 0;
      end
      if (ld) begin
         m_base = addr_in; m_cnt = 2'd0; m_lin = seq_linear; m_open = 1'b1;
      end
      m_mask = msk;
      m_wd   = wdata;
      m_addr = beat_of(m_base, m_cnt, m_lin);
   endtask

   task automatic compare(input string tag);
      logic ev;
      logic [W-1:0] ed;
      ev = (m_kind == 1) && !oe_n;
      ed = ev ? ref_mem[m_addr] : '0;
      chk({tag, " rvalid"}, {35'd0, rvalid}, {35'd0, ev});
      chk({tag, " rdata"}, rdata, ed);
   endtask

   task automatic cyc(input string tag);
      @(posedge clk);
      model_edge();
      #1;
      compare(tag);
   endtask

   task automatic idle_in();
      pstb_n = 1'b1; cstb_n = 1'b1; adv_n = 1'b1;
      gwr_n = 1'b1; lane_gate_n = 1'b1; lane_n = 4'hF;
      sel0_n = 1'b0; sel1_n = 1'b0; sel2 = 1'b1; oe_n = 1'b0;
   endtask

   task automatic c_start(input logic [AW-1:0] a);
      idle_in(); cstb_n = 1'b0; addr_in = a;
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20250611));
      m_kind = 0; m_open = 1'b0; m_base = '0; m_cnt = '0; m_lin = 1'b0;
      m_addr = '0; m_mask = '0; m_wd = '0;
      repeat (3) @(posedge clk);
      #1;
      chk("R2 reset rvalid", {35'd0, rvalid}, 36'd0);
      chk("R2 reset rdata", rdata, 36'd0);
      rst_n = 1'b1;

      // fill every word with a global write (R6, R5, R12)
      for (int a = 0; a < DEPTH; a++) begin
         c_start(AW'(a)); gwr_n = 1'b0; wdata = pat(AW'(a));
         snooze = a[0];
         cyc("R12 fill write");
      end
      idle_in(); snooze = 1'b0;

      // linear burst from low bits 01 (R9)
      c_start(8'h21); seq_linear = 1'b1;
      cyc("R9 lin beat0"); chk("R9 lin beat0", rdata, pat(8'h21));
      for (int n = 1; n < 4; n++) begin
         idle_in(); adv_n = 1'b0; seq_linear = 1'b0;
         cyc("R9 lin step");
         chk("R9 lin order", rdata, pat(beat_of(8'h21, 2'(n), 1'b1)));
      end
      idle_in();
      cyc("R8 suspend");
      chk("R8 suspend holds", rdata, pat(8'h20));

      // interleaved burst from low bits 01 (R10)
      c_start(8'h45); seq_linear = 1'b0;
      cyc("R10 ilv beat0");
      for (int n = 1; n < 4; n++) begin
         idle_in(); adv_n = 1'b0; seq_linear = 1'b1;
         cyc("R10 ilv step");
         chk("R10 ilv order", rdata, pat(beat_of(8'h45, 2'(n), 1'b0)));
      end

      // processor start with write controls active is a read (R3)
      idle_in(); pstb_n = 1'b0; addr_in = 8'h10; gwr_n = 1'b0; lane_gate_n = 1'b0;
      lane_n = 4'h0; wdata = '1;
      cyc("R3 pstb read");
      chk("R3 pstb read data", rdata, pat(8'h10));
      // write lane 0 in the following suspend cycle (R4, R7, R12)
      idle_in(); lane_gate_n = 1'b0; lane_n = 4'b1110; wdata = 36'hF_FFFF_FFAB;
      cyc("R4 follow-up write");
      chk("R12 write quiet", {35'd0, rvalid}, 36'd0);
      // lane enables ignored while gate is high (R7)
      c_start(8'h10); lane_n = 4'h0;
      cyc("R7 gate high read");
      chk("R7 lane0 only", rdata, {pat(8'h10)[35:9], 9'h1AB});

      // global write overrides lane controls (R6) then read-after-write (R14)
      c_start(8'h30); gwr_n = 1'b0; lane_gate_n = 1'b1; wdata = 36'h9_8765_4321;
      cyc("R6 global write");
      c_start(8'h30);
      cyc("R14 read after write");
      chk("R6 all lanes", rdata, 36'h9_8765_4321);

      // deselect paths (R1)
      c_start(8'h11); sel2 = 1'b0;
      cyc("R1 desel cstb");
      chk("R1 desel off", {35'd0, rvalid}, 36'd0);
      idle_in();
      cyc("R1 closed burst");
      chk("R1 stays idle", {35'd0, rvalid}, 36'd0);
      idle_in(); pstb_n = 1'b0; sel1_n = 1'b1; addr_in = 8'h12;
      cyc("R1 desel pstb");
      chk("R1 desel pstb off", rdata, 36'd0);

      // asynchronous output enable (R11) and sleep (R13)
      c_start(8'h50); oe_n = 1'b1; snooze = 1'b1;
      cyc("R11 oe high");
      chk("R11 gated data", rdata, 36'd0);
      oe_n = 1'b0; #0.5;
      chk("R11 async enable", {35'd0, rvalid}, 36'd1);
      chk("R13 read under snooze", rdata, pat(8'h50));
      snooze = 1'b0;

      // constrained random traffic against the reference
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = int'($urandom % 16);
         idle_in();
         pstb_n = !(r < 2);
         cstb_n = !(r >= 2 && r < 5);
         sel0_n = ($urandom % 12) == 0;
         sel1_n = ($urandom % 12) == 0;
         sel2   = ($urandom % 12) != 0;
         adv_n  = $urandom % 2;
         gwr_n  = ($urandom % 8) != 0;
         lane_gate_n = ($urandom % 3) != 0;
         lane_n = 4'($urandom);
         oe_n   = ($urandom % 4) == 0;
         seq_linear = $urandom % 2;
         snooze = $urandom % 2;
         addr_in = AW'($urandom);
         wdata = {4'($urandom), 32'($urandom)};
         cyc("R14 random mix");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule